// File: doc/BRIEF.md
# Three-Event Port Classification Sequencer

This block sits in the power-sourcing side of a power-over-cable port controller. When detection finds a valid load, it runs up to three classification events. Each event is a one-cycle trigger pulse to the analog front end. The front end later returns a digitized 3-bit class code. From the sequence of class codes the block decides what kind of device is attached: a basic Type 1 load, a Type 2 load, or an enhanced high-power load. It loads the policing-current and hard-limit threshold codes for that kind, then raises a power request.

A Class 4 answer to the first event leads to a second event. Class 4 answers to both the first and second events lead to a third event. If the third event answers with a class other than 4, the device is identified as an enhanced device. If it answers Class 4 again, the device stays at Type 2. Any answer below Class 4 in the first or second event ends classification at Type 1. A missing answer or an illegal class code (5 to 7) raises a fault, and the port is not powered.

The class-result input is a stream with valid/ready. `cls_ready` is high only while the block waits for the result of an event. A result is taken on a clock edge where `cls_valid` and `cls_ready` are both high. While `cls_ready` is low, the source must hold its result, and `cls_valid` has no effect. The detection start pulse, the port reset and every output are plain control pins.

Top module: `pse_class_seq`

## Requirements
- R1: After reset the block is idle: `pwr_req`=0, `dev_type`=0, `cut_code`=0, `lim_code`=0, `fault`=0, `evt_pulse`=0, `cls_ready`=0.
- R2: A `det_ok` sampled while idle produces `evt_pulse` high for exactly one cycle, in the following cycle, with `evt_idx`=1. A `det_ok` in any other state is ignored.
- R3: A first result of Class 0 to 3 ends classification. In the cycle after the accepting edge, `pwr_req`=1 and `dev_type`=1 (Type 1), and no further event pulse is issued.
- R4: A Class 4 result on event 1 or event 2 produces the next event pulse in the cycle after the accepting edge, with `evt_idx` equal to the accepted event's index plus one.
- R5: A second result of Class 0 to 3 gives `dev_type`=1 with `pwr_req`=1.
- R6: A third result of Class 4 gives `dev_type`=2 (Type 2). A third result of Class 0 to 3 gives `dev_type`=3 (enhanced).
- R7: While powered, `cut_code` and `lim_code` are the parameters for the decided type. They, `dev_type` and `pwr_req` stay stable until `port_reset`. A `port_reset` in any state returns the block to the R1 state on the next cycle.
- R8: The block waits at most `TMO_CYC` cycles with `cls_ready` high. A result on the last of those cycles is still accepted. If none arrives, the next cycle shows `fault`=1, `cls_ready`=0 and `pwr_req`=0.
- R9: A class code of 5, 6 or 7 on any event gives `fault`=1, idle and no power in the cycle after the accepting edge.
- R10: `cls_valid` while `cls_ready` is low changes no output.
- R11: `fault` stays set until the next accepted `det_ok` or `port_reset`, which clear it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_reset | input | 1 | Synchronous port clear; ends power and classification |
| det_ok | input | 1 | Detection-valid start pulse |
| cls_valid | input | 1 | Class result valid |
| cls_ready | output | 1 | Block is waiting for a class result |
| cls_code | input | 3 | Digitized class code |
| evt_pulse | output | 1 | One-cycle classification event trigger |
| evt_idx | output | 2 | Index (1 to 3) of the triggered event |
| dev_type | output | 2 | 0 none, 1 Type 1, 2 Type 2, 3 enhanced |
| cut_code | output | THR_W | Policing current threshold code |
| lim_code | output | THR_W | Hard current limit code |
| pwr_req | output | 1 | Power-on request |
| fault | output | 1 | Classification fault flag |

## Verification
The checker watches several properties on every cycle. Event pulses last one cycle and never overlap `cls_ready`. Power and fault never show together, and a powered port always carries a non-zero type. Thresholds and type stay stable while powered. An illegal code and a port reset each lead to their required states on the next cycle. The decision logic itself can only be shown by the bench's scenarios. These scenarios cover the type chosen for each class sequence, the next-event index, the timeout boundary at exactly `TMO_CYC` waiting cycles, and stray `det_ok` or `cls_valid` having no effect.

// File: rtl/pse_class_pkg.sv
package pse_class_pkg;
  typedef enum logic [1:0] {
    DEV_NONE = 2'd0,
    DEV_T1   = 2'd1,
    DEV_T2   = 2'd2,
    DEV_HP   = 2'd3
  } dev_type_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRIG  = 2'd1,
    ST_WAIT  = 2'd2,
    ST_POWER = 2'd3
  } seq_state_e;

  localparam logic [2:0] CLS_FOUR = 3'd4;
  localparam logic [1:0] LAST_EVT = 2'd3;
endpackage

// File: rtl/pse_class_timer.sv
module pse_class_timer #(
  parameter int TMO_CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(TMO_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (clr)    cnt_q <= '0;
    else if (run)    cnt_q <= cnt_q + 1'b1;
  end

  assign expired = run && (cnt_q == LAST);
endmodule

// File: rtl/pse_class_thr.sv
module pse_class_thr
  import pse_class_pkg::*;
#(
  parameter int THR_W = 8,
  parameter logic [THR_W-1:0] CUT_T1 = 8'd30,
  parameter logic [THR_W-1:0] CUT_T2 = 8'd60,
  parameter logic [THR_W-1:0] CUT_HP = 8'd200,
  parameter logic [THR_W-1:0] LIM_T1 = 8'd80,
  parameter logic [THR_W-1:0] LIM_T2 = 8'd140,
  parameter logic [THR_W-1:0] LIM_HP = 8'd240
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ld,
  input  dev_type_e        type_in,
  output logic [THR_W-1:0] cut_code,
  output logic [THR_W-1:0] lim_code
);
  logic [THR_W-1:0] cut_lu, lim_lu;

  always_comb begin
    unique case (type_in)
      DEV_T1:  begin cut_lu = CUT_T1; lim_lu = LIM_T1; end
      DEV_T2:  begin cut_lu = CUT_T2; lim_lu = LIM_T2; end
      DEV_HP:  begin cut_lu = CUT_HP; lim_lu = LIM_HP; end
      default: begin cut_lu = '0;     lim_lu = '0;     end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cut_code <= '0;
      lim_code <= '0;
    end else if (clr) begin
      cut_code <= '0;
      lim_code <= '0;
    end else if (ld) begin
      cut_code <= cut_lu;
      lim_code <= lim_lu;
    end
  end
endmodule

// File: rtl/pse_class_fsm.sv
module pse_class_fsm
  import pse_class_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       port_reset,
  input  logic       det_ok,
  input  logic       cls_valid,
  input  logic [2:0] cls_code,
  input  logic       tmo_exp,
  output logic       cls_ready,
  output logic       evt_pulse,
  output logic [1:0] evt_idx,
  output logic       tmr_clr,
  output logic       tmr_run,
  output logic       ld,
  output dev_type_e  type_nxt,
  output logic [1:0] dev_type,
  output logic       pwr_req,
  output logic       fault
);
  seq_state_e state_q, state_n;
  logic [1:0] idx_q, idx_n;
  dev_type_e  type_q, type_n;
  logic       fault_q, fault_n;
  logic       take;

  assign take = (state_q == ST_WAIT) && cls_valid;

  always_comb begin
    state_n  = state_q;
    idx_n    = idx_q;
    type_n   = type_q;
    fault_n  = fault_q;
    ld       = 1'b0;
    type_nxt = DEV_NONE;
    unique case (state_q)
      ST_IDLE: if (det_ok) begin
        state_n = ST_TRIG;
        idx_n   = 2'd1;
        fault_n = 1'b0;
      end
      ST_TRIG: state_n = ST_WAIT;
      ST_WAIT: begin
        if (take) begin
          if (cls_code > CLS_FOUR) begin
            fault_n = 1'b1;
            state_n = ST_IDLE;
          end else if (cls_code == CLS_FOUR && idx_q != LAST_EVT) begin
            idx_n   = idx_q + 2'd1;
            state_n = ST_TRIG;
          end else begin
            if (idx_q != LAST_EVT)          type_nxt = DEV_T1;
            else if (cls_code == CLS_FOUR)  type_nxt = DEV_T2;
            else                            type_nxt = DEV_HP;
            ld      = 1'b1;
            type_n  = type_nxt;
            state_n = ST_POWER;
          end
        end else if (tmo_exp) begin
          fault_n = 1'b1;
          state_n = ST_IDLE;
        end
      end
      default: state_n = ST_POWER;
    endcase
    if (port_reset) begin
      state_n = ST_IDLE;
      idx_n   = 2'd0;
      type_n  = DEV_NONE;
      fault_n = 1'b0;
      ld      = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= 2'd0;
      type_q  <= DEV_NONE;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_n;
      idx_q   <= idx_n;
      type_q  <= type_n;
      fault_q <= fault_n;
    end
  end

  assign cls_ready = (state_q == ST_WAIT);
  assign evt_pulse = (state_q == ST_TRIG);
  assign evt_idx   = idx_q;
  assign tmr_clr   = (state_q == ST_TRIG);
  assign tmr_run   = (state_q == ST_WAIT);
  assign pwr_req   = (state_q == ST_POWER);
  assign dev_type  = type_q;
  assign fault     = fault_q;
endmodule

// File: rtl/pse_class_seq.sv
module pse_class_seq
  import pse_class_pkg::*;
#(
  parameter int TMO_CYC = 16,
  parameter int THR_W = 8,
  parameter logic [THR_W-1:0] CUT_T1 = 8'd30,
  parameter logic [THR_W-1:0] CUT_T2 = 8'd60,
  parameter logic [THR_W-1:0] CUT_HP = 8'd200,
  parameter logic [THR_W-1:0] LIM_T1 = 8'd80,
  parameter logic [THR_W-1:0] LIM_T2 = 8'd140,
  parameter logic [THR_W-1:0] LIM_HP = 8'd240
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             port_reset,
  input  logic             det_ok,
  input  logic             cls_valid,
  output logic             cls_ready,
  input  logic [2:0]       cls_code,
  output logic             evt_pulse,
  output logic [1:0]       evt_idx,
  output logic [1:0]       dev_type,
  output logic [THR_W-1:0] cut_code,
  output logic [THR_W-1:0] lim_code,
  output logic             pwr_req,
  output logic             fault
);
  logic      tmo_exp, tmr_clr, tmr_run, ld;
  dev_type_e type_nxt;

  pse_class_timer #(.TMO_CYC(TMO_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .run(tmr_run), .expired(tmo_exp)
  );

  pse_class_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .port_reset(port_reset), .det_ok(det_ok),
    .cls_valid(cls_valid), .cls_code(cls_code), .tmo_exp(tmo_exp),
    .cls_ready(cls_ready), .evt_pulse(evt_pulse), .evt_idx(evt_idx),
    .tmr_clr(tmr_clr), .tmr_run(tmr_run), .ld(ld), .type_nxt(type_nxt),
    .dev_type(dev_type), .pwr_req(pwr_req), .fault(fault)
  );

  pse_class_thr #(
    .THR_W(THR_W), .CUT_T1(CUT_T1), .CUT_T2(CUT_T2), .CUT_HP(CUT_HP),
    .LIM_T1(LIM_T1), .LIM_T2(LIM_T2), .LIM_HP(LIM_HP)
  ) u_thr (
    .clk(clk), .rst_n(rst_n), .clr(port_reset), .ld(ld), .type_in(type_nxt),
    .cut_code(cut_code), .lim_code(lim_code)
  );
endmodule

// File: rtl/pse_class_seq_chk.sv
module pse_class_seq_chk #(
  parameter int THR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             port_reset,
  input logic             cls_valid,
  input logic             cls_ready,
  input logic [2:0]       cls_code,
  input logic             evt_pulse,
  input logic [1:0]       evt_idx,
  input logic [1:0]       dev_type,
  input logic [THR_W-1:0] cut_code,
  input logic [THR_W-1:0] lim_code,
  input logic             pwr_req,
  input logic             fault
);
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |=> !evt_pulse);

  a_r4_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> (evt_idx != 2'd0));

  a_r10_ready_vs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    !(cls_ready && evt_pulse));

  a_r8_no_fault_powered: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault && pwr_req));

  a_r6_power_has_type: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_req |-> (dev_type != 2'd0));

  a_r7_hold_while_on: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_req && !port_reset) |=>
      (pwr_req && $stable(dev_type) && $stable(cut_code) && $stable(lim_code)));

  a_r7_port_clear: assert property (@(posedge clk) disable iff (!rst_n)
    port_reset |=> (!pwr_req && dev_type == 2'd0 && !fault && !cls_ready));

  a_r9_bad_code: assert property (@(posedge clk) disable iff (!rst_n)
    (cls_ready && cls_valid && cls_code > 3'd4 && !port_reset) |=>
      (fault && !pwr_req && !cls_ready));
endmodule

bind pse_class_seq pse_class_seq_chk #(.THR_W(THR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .port_reset(port_reset), .cls_valid(cls_valid),
  .cls_ready(cls_ready), .cls_code(cls_code), .evt_pulse(evt_pulse),
  .evt_idx(evt_idx), .dev_type(dev_type), .cut_code(cut_code),
  .lim_code(lim_code), .pwr_req(pwr_req), .fault(fault)
);

// File: tb/pse_class_seq_tb.sv
`timescale 1ns/1ps
module pse_class_seq_tb;
  localparam int TMO = 6;
  localparam logic [7:0] C1 = 8'd11, C2 = 8'd22, C3 = 8'd33;
  localparam logic [7:0] L1 = 8'd44, L2 = 8'd55, L3 = 8'd66;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_reset = 1'b0, det_ok = 1'b0, cls_valid = 1'b0;
  logic [2:0] cls_code = 3'd0;
  logic cls_ready, evt_pulse, pwr_req, fault;
  logic [1:0] evt_idx, dev_type;
  logic [7:0] cut_code, lim_code;
  int nchk = 0, nerr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pse_class_seq #(.TMO_CYC(TMO), .THR_W(8), .CUT_T1(C1), .CUT_T2(C2),
    .CUT_HP(C3), .LIM_T1(L1), .LIM_T2(L2), .LIM_HP(L3)) u_dut (
    .clk(clk), .rst_n(rst_n), .port_reset(port_reset), .det_ok(det_ok),
    .cls_valid(cls_valid), .cls_ready(cls_ready), .cls_code(cls_code),
    .evt_pulse(evt_pulse), .evt_idx(evt_idx), .dev_type(dev_type),
    .cut_code(cut_code), .lim_code(lim_code), .pwr_req(pwr_req), .fault(fault));

  function automatic logic [7:0] exp_cut(input logic [1:0] t);
    case (t) 2'd1: return C1; 2'd2: return C2; 2'd3: return C3; default: return 8'd0; endcase
  endfunction
  function automatic logic [7:0] exp_lim(input logic [1:0] t);
    case (t) 2'd1: return L1; 2'd2: return L2; 2'd3: return L3; default: return 8'd0; endcase
  endfunction
  // expected type once the event with index e answers c (0..4)
  function automatic logic [1:0] exp_type(input int e, input logic [2:0] c);
    if (e < 3) return 2'd1;
    return (c == 3'd4) ? 2'd2 : 2'd3;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic start_seq();
    det_ok = 1'b1;
    @(negedge clk);
    det_ok = 1'b0;
    chk(evt_pulse && evt_idx == 2'd1, "R2 first event pulse", {evt_pulse, evt_idx}, 5);
    chk(!fault, "R11 fault cleared by start", fault, 0);
  endtask

  // runs up to three events; returns 1 when powered
  task automatic run_seq(input logic [2:0] c1, input logic [2:0] c2,
                         input logic [2:0] c3, output bit powered);
    logic [2:0] cs [3];
    cs[0] = c1; cs[1] = c2; cs[2] = c3;
    powered = 1'b0;
    start_seq();
    for (int e = 1; e <= 3; e++) begin
      int d;
      @(negedge clk);
      chk(cls_ready && !evt_pulse, "R2 pulse one cycle, ready follows", {evt_pulse, cls_ready}, 1);
      d = int'($urandom % TMO);
      repeat (d) @(negedge clk);
      cls_valid = 1'b1;
      cls_code = cs[e-1];
      @(negedge clk);
      cls_valid = 1'b0;
      if (cs[e-1] > 3'd4) begin
        chk(fault && !pwr_req && !cls_ready, "R9 illegal code fault", {fault, pwr_req, cls_ready}, 4);
        return;
      end
      if (cs[e-1] == 3'd4 && e < 3) begin
        chk(evt_pulse && evt_idx == 2'(e + 1), "R4 next event", evt_idx, e + 1);
      end else begin
        logic [1:0] t;
        t = exp_type(e, cs[e-1]);
        chk(pwr_req && dev_type == t, e == 1 ? "R3 type" : (e == 2 ? "R5 type" : "R6 type"),
            dev_type, t);
        chk(cut_code == exp_cut(t) && lim_code == exp_lim(t), "R7 thresholds",
            cut_code, exp_cut(t));
        chk(!evt_pulse, "R3 no further event", evt_pulse, 0);
        powered = 1'b1;
        return;
      end
    end
  endtask

  task automatic do_port_reset();
    port_reset = 1'b1;
    @(negedge clk);
    port_reset = 1'b0;
    chk(!pwr_req && dev_type == 0 && cut_code == 0 && lim_code == 0 && !fault && !cls_ready,
        "R7 port reset clears", {pwr_req, dev_type}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    bit pw;
    logic [1:0] t0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!pwr_req && dev_type == 0 && cut_code == 0 && lim_code == 0 && !fault
        && !evt_pulse && !cls_ready, "R1 reset state", {pwr_req, dev_type, fault}, 0);

    // R10: stray valid while idle
    cls_valid = 1'b1; cls_code = 3'd4;
    @(negedge clk);
    cls_valid = 1'b0;
    chk(!evt_pulse && !cls_ready && !pwr_req && !fault, "R10 valid ignored when idle",
        {evt_pulse, cls_ready, pwr_req}, 0);

    // directed paths
    run_seq(3'd2, 3'd0, 3'd0, pw); do_port_reset();
    run_seq(3'd4, 3'd1, 3'd0, pw); do_port_reset();
    run_seq(3'd4, 3'd4, 3'd4, pw);
    // R2/R10: stray start and valid while powered
    t0 = dev_type;
    det_ok = 1'b1; cls_valid = 1'b1; cls_code = 3'd0;
    @(negedge clk);
    det_ok = 1'b0; cls_valid = 1'b0;
    @(negedge clk);
    chk(pwr_req && dev_type == t0 && !evt_pulse && cut_code == C2, "R10 inputs ignored when powered",
        dev_type, t0);
    do_port_reset();
    run_seq(3'd4, 3'd4, 3'd3, pw); do_port_reset();
    run_seq(3'd4, 3'd4, 3'd6, pw);
    chk(fault, "R11 fault held", fault, 1);
    @(negedge clk);
    chk(fault && !pwr_req, "R11 fault persists in idle", fault, 1);

    // R8 timeout boundary
    start_seq();
    repeat (TMO) @(negedge clk);
    chk(cls_ready && !fault, "R8 still waiting on last cycle", {cls_ready, fault}, 2);
    @(negedge clk);
    chk(fault && !cls_ready && !pwr_req, "R8 timeout fault", {fault, cls_ready}, 2);
    // R8: result on the last waiting cycle is accepted
    start_seq();
    repeat (TMO) @(negedge clk);
    cls_valid = 1'b1; cls_code = 3'd1;
    @(negedge clk);
    cls_valid = 1'b0;
    chk(pwr_req && dev_type == 2'd1 && !fault, "R8 last-cycle result accepted", dev_type, 1);
    do_port_reset();
    // R7: port reset while waiting
    start_seq();
    @(negedge clk);
    do_port_reset();
    @(negedge clk);
    chk(!evt_pulse && !cls_ready && !pwr_req, "R7 reset mid-classification", cls_ready, 0);

    // constrained random
    for (int i = 0; i < 60; i++) begin
      logic [2:0] r [3];
      for (int k = 0; k < 3; k++)
        r[k] = ($urandom % 8 < 5) ? 3'd4 : 3'($urandom % 8);
      run_seq(r[0], r[1], r[2], pw);
      if (pw) begin
        repeat (int'($urandom % 4)) @(negedge clk);
        do_port_reset();
      end
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule